// File: doc/BRIEF.md
# Interleaved Digit-Serial Modular Multiplier

This unit computes the residue of the product of two wide unsigned operands with respect to a normalized modulus, over several clock cycles. It does not form the full double-width product. The multiplier operand is consumed one small digit per cycle, starting from its most significant digit. In each cycle the running value is shifted left by one digit width, and the current digit times the multiplicand is added to it. An estimated multiple of the modulus is then removed in the same cycle. Because of this, the running value never grows more than a few bits past the modulus width.

The multiple to remove is found by multiplying the top bits of the running value by a cached reciprocal of the modulus. This estimate never exceeds the true quotient and falls short by at most one. After the last digit, a single conditional subtraction brings the value into range.

Loading a modulus starts a short serial computation of the reciprocal. Later multiplications reuse that cached reciprocal until a new modulus is loaded. A typical user loads the modulus once, then issues a stream of start strobes, each with a new pair of operands. The user waits for the one-cycle done pulse after each strobe.

Top module: `modmul_interleaved`

## Requirements
- R1: When `loadMod` is high on a clock edge while the unit is idle, `modIn` is captured as the modulus. `busy` then stays high for exactly S+2 = 10 cycles while the reciprocal floor(2^(N+S)/C) is computed, with S = 8.
- R2: When `start` is high on a clock edge while the unit is idle and a modulus is loaded, `aIn` and `bIn` are captured. `done` rises on the 9th clock edge after that edge: 8 digit cycles and 1 correction cycle, with N = 32 and K = 4.
- R3: The running value always stays below twice the modulus, so the 38-bit accumulator never overflows.
- R4: When `done` is high, `result` equals (A·B) mod C. This holds for any 32-bit A, for any B < C, and for any C with bit 31 set. The result is always below C.
- R5: `done` is high for exactly one cycle per multiplication. `result` holds its value until the next `done`.
- R6: `start` and `loadMod` have no effect while `busy` is high. The running multiplication finishes with its captured operands and modulus.
- R7: `start` has no effect before a modulus has been loaded since reset: `busy` and `done` stay low.
- R8: The modulus and its reciprocal persist across multiplications. A later `start` without `loadMod` uses the last loaded modulus, and a new load replaces it.
- R9: After reset, `busy`, `done` and `result` are all zero.
- R10: If `loadMod` and `start` are both high on the same idle edge, the load takes priority and the start is dropped: no `done` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| loadMod | input | 1 | Capture a new modulus and compute its reciprocal |
| modIn | input | 32 | Modulus C, bit 31 must be set |
| start | input | 1 | Begin a multiplication |
| aIn | input | 32 | Multiplier A, consumed digit by digit |
| bIn | input | 32 | Multiplicand B, must be below C |
| busy | output | 1 | High while a load or multiplication is in progress |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | 32 | (A·B) mod C |

## Verification
Several moduli are used: the smallest normalized one (2^31), the all-ones word, an odd value just above 2^31, and a value near 2^32. Each reaches the opposite bound of the reciprocal range and of the quotient-estimate error. The operand pairs include all-ones A with B = C−1, which drives the accumulator to its largest value and the estimated quotient to its maximum. Zero operands show whether any reduction step removes a spurious multiple, and small operands show whether the final correction subtracts when it should not. Directed sequences probe the timing and control: strobes issued while busy, a start with no modulus loaded, and simultaneous strobes. Reusing a modulus after a multiplication and then replacing it checks whether the cached reciprocal is really kept or really refreshed.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef struct packed {
    logic latchMod;   // capture modulus, clear reciprocal state
    logic recipStep;  // one reciprocal quotient bit
    logic latchOps;   // capture operands, clear accumulator
    logic stepDigit;  // one digit accumulate and reduce
    logic finish;     // final conditional subtraction
  } mmCtrl_t;
endpackage

// File: rtl/mm_recip.sv
module mm_recip #(
  parameter int N  = 32,
  parameter int S  = 8,
  parameter int IW = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           init,
  input  logic           step,
  input  logic [IW-1:0]  idx,
  input  logic [N-1:0]   modulus,
  output logic [S+1:0]   recip
);
  localparam int RMW = N + S + 1;  // partial remainder width
  localparam int SHW = N + S + 2;  // shifted divisor width

  logic [RMW-1:0] remReg;
  logic [SHW-1:0] shiftedMod;
  logic           takeBit;

  assign shiftedMod = SHW'(modulus) << idx;
  assign takeBit    = {1'b0, remReg} >= shiftedMod;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg <= '0;
      recip  <= '0;
    end else if (init) begin
      remReg <= RMW'(1) << (N + S);
      recip  <= '0;
    end else if (step && takeBit) begin
      remReg <= RMW'({1'b0, remReg} - shiftedMod);
      recip  <= recip | ((S+2)'(1) << idx);
    end
  end
endmodule

// File: rtl/mm_datapath.sv
module mm_datapath
  import mm_pkg::*;
#(
  parameter int N  = 32,
  parameter int K  = 4,
  parameter int S  = 8,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  mmCtrl_t       ctrl,
  input  logic [IW-1:0] stepIdx,
  input  logic [N-1:0]  modIn,
  input  logic [N-1:0]  aIn,
  input  logic [N-1:0]  bIn,
  output logic [N-1:0]  modulus,
  output logic [N+K+1:0] accum,
  output logic [N-1:0]  result
);
  localparam int W   = N + K + 2;     // accumulator width
  localparam int RW  = S + 2;         // reciprocal width
  localparam int DHW = W - (N - 2);   // truncated top of accumulator
  localparam int PW  = DHW + RW;      // estimate product width

  logic [N-1:0]   cReg, aSh, bReg;
  logic [W-1:0]   dReg, accSum, qTimesC, dNext;
  logic [K-1:0]   digit;
  logic [RW-1:0]  recip;
  logic [DHW-1:0] dTop, qEst;
  logic [PW-1:0]  estProd;

  mm_recip #(.N(N), .S(S), .IW(IW)) i_recip (
    .clk(clk), .rstN(rstN),
    .init(ctrl.latchMod), .step(ctrl.recipStep), .idx(stepIdx),
    .modulus(cReg), .recip(recip)
  );

  assign digit   = aSh[N-1 -: K];
  assign accSum  = (dReg << K) + W'(digit) * W'(bReg);
  assign dTop    = accSum[W-1 : N-2];
  assign estProd = PW'(dTop) * PW'(recip);
  assign qEst    = DHW'(estProd >> (S + 2));
  assign qTimesC = W'(qEst) * W'(cReg);
  assign dNext   = accSum - qTimesC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cReg   <= '0;
      aSh    <= '0;
      bReg   <= '0;
      dReg   <= '0;
      result <= '0;
    end else begin
      if (ctrl.latchMod) begin
        cReg <= modIn;
        dReg <= '0;
      end
      if (ctrl.latchOps) begin
        aSh  <= aIn;
        bReg <= bIn;
        dReg <= '0;
      end
      if (ctrl.stepDigit) begin
        aSh  <= aSh << K;
        dReg <= dNext;
      end
      if (ctrl.finish) begin
        result <= (dReg >= W'(cReg)) ? N'(dReg - W'(cReg)) : dReg[N-1:0];
      end
    end
  end

  assign modulus = cReg;
  assign accum   = dReg;
endmodule

// File: rtl/mm_control.sv
module mm_control
  import mm_pkg::*;
#(
  parameter int N  = 32,
  parameter int K  = 4,
  parameter int S  = 8,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadMod,
  input  logic          start,
  output mmCtrl_t       ctrl,
  output logic [IW-1:0] stepIdx,
  output logic          busy,
  output logic          done
);
  localparam int L      = N / K;
  localparam int RSTEPS = S + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_RECIP, ST_RUN, ST_FIX} mmState_t;

  mmState_t      state;
  logic [IW-1:0] cnt;
  logic          recipValid;

  always_comb begin
    ctrl = '0;
    unique case (state)
      ST_IDLE: begin
        if (loadMod)                 ctrl.latchMod = 1'b1;
        else if (start && recipValid) ctrl.latchOps = 1'b1;
      end
      ST_RECIP: ctrl.recipStep = 1'b1;
      ST_RUN:   ctrl.stepDigit = 1'b1;
      ST_FIX:   ctrl.finish    = 1'b1;
      default:  ctrl = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      recipValid <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= (state == ST_FIX);
      unique case (state)
        ST_IDLE: begin
          if (ctrl.latchMod) begin
            state      <= ST_RECIP;
            cnt        <= IW'(RSTEPS - 1);
            recipValid <= 1'b0;
          end else if (ctrl.latchOps) begin
            state <= ST_RUN;
            cnt   <= IW'(L - 1);
          end
        end
        ST_RECIP: begin
          if (cnt == '0) begin
            state      <= ST_IDLE;
            recipValid <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RUN: begin
          if (cnt == '0) state <= ST_FIX;
          else           cnt   <= cnt - 1'b1;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign stepIdx = cnt;
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/modmul_interleaved.sv
module modmul_interleaved
  import mm_pkg::*;
#(
  parameter int N = 32,
  parameter int K = 4,
  parameter int S = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         loadMod,
  input  logic [N-1:0] modIn,
  input  logic         start,
  input  logic [N-1:0] aIn,
  input  logic [N-1:0] bIn,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] result
);
  localparam int L    = N / K;
  localparam int MAXC = (L > S + 2) ? L : S + 2;
  localparam int IW   = $clog2(MAXC) + 1;

  mmCtrl_t       ctrl;
  logic [IW-1:0] stepIdx;
  logic [N-1:0]  modulus;
  logic [N+K+1:0] accum;

  mm_control #(.N(N), .K(K), .S(S), .IW(IW)) i_control (
    .clk(clk), .rstN(rstN), .loadMod(loadMod), .start(start),
    .ctrl(ctrl), .stepIdx(stepIdx), .busy(busy), .done(done)
  );

  mm_datapath #(.N(N), .K(K), .S(S), .IW(IW)) i_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .stepIdx(stepIdx),
    .modIn(modIn), .aIn(aIn), .bIn(bIn),
    .modulus(modulus), .accum(accum), .result(result)
  );
endmodule

// File: rtl/modmul_chk.sv
module modmul_chk #(
  parameter int N = 32,
  parameter int K = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           busy,
  input logic           done,
  input logic [N-1:0]   result,
  input logic [N-1:0]   modulus,
  input logic [N+K+1:0] accum
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accum != '0) |-> (accum < ((N+K+2)'(modulus) << 1)));

  assert_result_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result < modulus));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !done |=> (done || $stable(result)));

  assert_modulus_locked_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(modulus));

  assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));
endmodule

bind modmul_interleaved modmul_chk #(.N(N), .K(K)) i_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .result(result),
  .modulus(modulus), .accum(accum)
);

// File: tb/test_modmul_interleaved.sv
module test_modmul_interleaved;
  typedef struct packed {
    logic [31:0] c;
    logic [31:0] a;
    logic [31:0] b;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'hFFFF_FFFB, 32'h1234_5678, 32'h9ABC_DEF0},
    '{32'hFFFF_FFFB, 32'hFFFF_FFFF, 32'hFFFF_FFFA},
    '{32'hFFFF_FFFB, 32'h0000_0000, 32'h0000_1234},
    '{32'h8000_0000, 32'hDEAD_BEEF, 32'h7FFF_FFFF},
    '{32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
    '{32'hC000_0001, 32'h8765_4321, 32'hBFFF_FFFF},
    '{32'hC000_0001, 32'h0000_0001, 32'h5555_5555},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE},
    '{32'h8000_0001, 32'hF0F0_F0F0, 32'h8000_0000},
    '{32'hA5A5_A5A5, 32'h0000_000F, 32'h0000_0001}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadMod = 1'b0;
  logic [31:0] modIn = '0;
  logic        start = 1'b0;
  logic [31:0] aIn = '0;
  logic [31:0] bIn = '0;
  logic        busy, done;
  logic [31:0] result;

  int testsRun = 0;
  int testsFailed = 0;
  int cycleCount = 0;

  always #10 clk = ~clk;

  modmul_interleaved i_modmul_interleaved (
    .clk(clk), .rstN(rstN), .loadMod(loadMod), .modIn(modIn),
    .start(start), .aIn(aIn), .bIn(bIn),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [31:0] refMod(logic [31:0] c, logic [31:0] a, logic [31:0] b);
    longint unsigned p;
    p = longint'(a) * longint'(b);
    return 32'(p % longint'(c));
  endfunction

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic loadModulus(logic [31:0] c, output int busyCycles);
    @(negedge clk);
    loadMod = 1'b1; modIn = c;
    @(negedge clk);
    loadMod = 1'b0;
    busyCycles = 0;
    while (busy && busyCycles < 100) begin
      busyCycles++;
      @(negedge clk);
    end
  endtask

  task automatic multiply(logic [31:0] a, logic [31:0] b, output logic [31:0] res,
                          output int lat);
    @(negedge clk);
    start = 1'b1; aIn = a; bIn = b;
    @(negedge clk);
    start = 1'b0; aIn = '0; bIn = '0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    res = result;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycleCount++;
      if (cycleCount > 100000) begin
        testsFailed++;
        testsRun++;
        $display("FAIL watchdog actual=%0d expected=below 100000", cycleCount);
        $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
        $finish;
      end
    end
  end

  initial begin
    int bc, lat, seen;
    logic [31:0] res, curC;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 busy", busy, 0);
    check("R9 done", done, 0);
    check("R9 result", result, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R7: start before any modulus is loaded is ignored
    start = 1'b1; aIn = 32'h5; bIn = 32'h7;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int i = 0; i < 15; i++) begin
      if (busy || done) seen++;
      @(negedge clk);
    end
    check("R7 no activity", seen, 0);

    // R1, R4, R2, R5, R8: vector table
    curC = '0;
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].c != curC) begin
        loadModulus(VECS[v].c, bc);
        check("R1 load busy cycles", bc, 10);
        curC = VECS[v].c;
      end
      multiply(VECS[v].a, VECS[v].b, res, lat);
      check("R4 residue", res, refMod(VECS[v].c, VECS[v].a, VECS[v].b));
      check("R2 latency", lat, 9);
      @(negedge clk);
      check("R5 done one cycle", done, 0);
      check("R5 result held", result, res);
    end

    // R8: modulus kept across starts (last loaded was A5A5A5A5)
    multiply(32'hFFFF_FFFF, 32'hA5A5_A5A4, res, lat);
    check("R8 reuse modulus", res, refMod(32'hA5A5_A5A5, 32'hFFFF_FFFF, 32'hA5A5_A5A4));

    // R6: strobes while busy are ignored
    @(negedge clk);
    start = 1'b1; aIn = 32'h1357_9BDF; bIn = 32'h2468_ACE0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    loadMod = 1'b1; modIn = 32'h8000_0003;
    start = 1'b1; aIn = 32'h1; bIn = 32'h1;
    @(negedge clk);
    loadMod = 1'b0; start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check("R6 busy strobes ignored", result,
          refMod(32'hA5A5_A5A5, 32'h1357_9BDF, 32'h2468_ACE0));
    @(negedge clk);
    check("R6 no second done", busy | done, 0);
    multiply(32'h0000_0002, 32'h5A5A_5A5A, res, lat);
    check("R6 modulus unchanged", res, refMod(32'hA5A5_A5A5, 32'h2, 32'h5A5A_5A5A));

    // R10: simultaneous load and start -> load wins
    @(negedge clk);
    loadMod = 1'b1; modIn = 32'h8000_0001;
    start = 1'b1; aIn = 32'hFFFF_FFFF; bIn = 32'h3;
    @(negedge clk);
    loadMod = 1'b0; start = 1'b0;
    bc = 0; seen = 0;
    for (int i = 0; i < 25; i++) begin
      if (busy) bc++;
      if (done) seen++;
      @(negedge clk);
    end
    check("R10 busy only for load", bc, 10);
    check("R10 no done", seen, 0);
    // R8: new modulus in effect
    multiply(32'hFFFF_FFFF, 32'h8000_0000, res, lat);
    check("R8 new modulus", res, refMod(32'h8000_0001, 32'hFFFF_FFFF, 32'h8000_0000));

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule